// File: doc/BRIEF.md
# SATA Link Power State Controller

This block is the host-side policy engine that decides when a SATA link leaves the active state for one of two idle states and when it comes back. The shallow idle state is called partial and the deep one is called slumber. It watches command issue and completion strobes, the count of outstanding commands supplied by the command layer, and a power-down request from the attached device. From these it raises one of three link-state requests (enter partial, enter slumber, wake) and holds that request until the link layer acknowledges it.

The host enters partial at once when a command completes and none are outstanding. Slumber is reached only after a long idle period with no commands outstanding. The device may ask for partial. Within a command that request is granted at once. Between commands it is granted only after a short grace period, so that the host can act first. A command issued while the link is idle is held back and the link is woken. Held commands are released one per cycle once the link is active again. A latency-requirement output tells the platform to stay responsive in every state except slumber.

All timeouts are counted in microsecond ticks from a free-running prescaler of `CLK_PER_US` clock cycles.

Top module: `sata_lpm_ctrl`

## Requirements
- R1: During and after reset the link state reads active (`link_st` = 2'b00), no request output is high, `lat_tight` is 1 and `cmd_go` is 0.
- R2: In active, a `cmd_done` strobe seen while `pend_cnt` is zero raises `req_partial` on the next clock edge, with no timeout.
- R3: In active, a `cmd_done` strobe seen while `pend_cnt` is nonzero has no effect: the link stays active and no request is raised.
- R4: In active or partial, once `SLUMBER_US` ticks have passed with `pend_cnt` zero, no command strobe and no held command, `req_slumber` rises on the following edge. Any issue or completion strobe restarts that count.
- R5: While `pend_cnt` is nonzero the slumber count does not advance, so slumber is never requested with commands outstanding.
- R6: In active with `pend_cnt` nonzero, a device request (`dev_req`) raises `req_partial` on the next edge.
- R7: In active with `pend_cnt` zero, a device request is granted only after it has been held for `DEV_US` consecutive ticks, with `req_partial` rising on the edge after that. Dropping the request earlier discards the progress made.
- R8: If the slumber count and the device grace period both expire on the same edge, the host slumber request wins.
- R9: Each request output stays high until `link_ack` is sampled high. The link then reports its new state on `link_st`, encoded as active 2'b00, partial 2'b01, slumber 2'b10 and any transition 2'b11.
- R10: A `cmd_issue` strobe in partial or slumber raises `req_wake` on the next edge. Strobes seen in any state other than active are held. After the acknowledged return to active, `cmd_go` pulses once per held command on consecutive edges, starting on the second edge after the acknowledge.
- R11: In active with nothing held, a `cmd_issue` strobe gives a one-cycle `cmd_go` pulse on the next edge.
- R12: `lat_tight` is 0 exactly while the link is settled in slumber, and 1 in active, partial and every transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_issue | input | 1 | One-cycle strobe: a command is issued |
| cmd_done | input | 1 | One-cycle strobe: a command completed |
| pend_cnt | input | PEND_W | Number of commands still outstanding |
| dev_req | input | 1 | Device asks for partial (level) |
| link_ack | input | 1 | Link layer accepts the current request |
| req_partial | output | 1 | Request entry to partial |
| req_slumber | output | 1 | Request entry to slumber |
| req_wake | output | 1 | Request return to active |
| link_st | output | 2 | Settled link state or 2'b11 in transition |
| lat_tight | output | 1 | Platform must keep low service latency |
| cmd_go | output | 1 | Command released to the transport layer |

## Verification
Each request output is a decode of a single state register, so it changes on the first edge after its cause. The slumber request comes `SLUMBER_US`+1 edges after the last clearing edge, and a between-command device grant comes `DEV_US`+1 edges after the first edge that sees the request. A released command appears one edge after issue in active, or two edges after the wake acknowledge. The bench runs with one clock per tick so that these counts are exact. It drives inputs one time unit after an edge, steps edge by edge, samples just after each edge and checks both the cycle before a due result and the cycle it lands. The priority case places the device request so that both counters expire on the same edge.

// File: rtl/sata_lpm_ctrl.sv
module sata_lpm_ctrl #(
  parameter int CLK_PER_US = 100,
  parameter int SLUMBER_US = 10000,
  parameter int DEV_US     = 5,
  parameter int PEND_W     = 5,
  parameter int HOLD_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_issue,
  input  logic              cmd_done,
  input  logic [PEND_W-1:0] pend_cnt,
  input  logic              dev_req,
  input  logic              link_ack,
  output logic              req_partial,
  output logic              req_slumber,
  output logic              req_wake,
  output logic [1:0]        link_st,
  output logic              lat_tight,
  output logic              cmd_go
);

  localparam int PRE_W = $clog2(CLK_PER_US) + 1;
  localparam int SLW   = $clog2(SLUMBER_US + 1);
  localparam int DVW   = $clog2(DEV_US + 1);

  typedef enum logic [2:0] {S_ACT, S_GO_P, S_PART, S_GO_S, S_SLUM, S_WAKE} st_t;

  st_t              st, nxt;
  logic [PRE_W-1:0] pre;
  logic [SLW-1:0]   idle_cnt;
  logic [DVW-1:0]   dev_cnt;
  logic [HOLD_W-1:0] hold;

  wire us_tick  = (pre == PRE_W'(CLK_PER_US - 1));
  wire no_pend  = (pend_cnt == '0);
  wire no_hold  = (hold == '0);
  wire wakeable = cmd_issue || !no_hold;
  wire quiet    = no_pend && !cmd_issue && !cmd_done && no_hold &&
                  (st == S_ACT || st == S_PART);
  wire dev_arm  = dev_req && no_pend && no_hold && (st == S_ACT);
  wire slum_due = quiet && (idle_cnt == SLW'(SLUMBER_US));
  wire dev_due  = dev_arm && (dev_cnt == DVW'(DEV_US));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= us_tick ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                      idle_cnt <= '0;
    else if (!quiet)                                 idle_cnt <= '0;
    else if (us_tick && idle_cnt != SLW'(SLUMBER_US)) idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  dev_cnt <= '0;
    else if (!dev_arm)                           dev_cnt <= '0;
    else if (us_tick && dev_cnt != DVW'(DEV_US)) dev_cnt <= dev_cnt + 1'b1;

  always_comb begin
    nxt = st;
    case (st)
      S_ACT:
        if (wakeable)                   nxt = S_ACT;
        else if (slum_due)              nxt = S_GO_S;
        else if (cmd_done && no_pend)   nxt = S_GO_P;
        else if (dev_req && !no_pend)   nxt = S_GO_P;
        else if (dev_due)               nxt = S_GO_P;
      S_GO_P:  if (link_ack) nxt = S_PART;
      S_GO_S:  if (link_ack) nxt = S_SLUM;
      S_PART:
        if (wakeable)      nxt = S_WAKE;
        else if (slum_due) nxt = S_GO_S;
      S_SLUM:  if (wakeable) nxt = S_WAKE;
      S_WAKE:  if (link_ack) nxt = S_ACT;
      default: nxt = S_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_ACT;
    else        st <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold   <= '0;
      cmd_go <= 1'b0;
    end else begin
      cmd_go <= (st == S_ACT) && wakeable;
      if (st == S_ACT) begin
        if (!no_hold && !cmd_issue) hold <= hold - 1'b1;
      end else if (cmd_issue && hold != '1) begin
        hold <= hold + 1'b1;
      end
    end

  assign req_partial = (st == S_GO_P);
  assign req_slumber = (st == S_GO_S);
  assign req_wake    = (st == S_WAKE);
  assign lat_tight   = (st != S_SLUM);
  assign link_st     = (st == S_ACT)  ? 2'b00 :
                       (st == S_PART) ? 2'b01 :
                       (st == S_SLUM) ? 2'b10 : 2'b11;

  p_host_within_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT) && cmd_done && !no_pend && !dev_req |=> !req_partial);

  p_no_slumber_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !no_pend && (st == S_ACT || st == S_PART) |=> !req_slumber);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_partial || req_slumber || req_wake) && !link_ack
      |=> $stable({req_partial, req_slumber, req_wake}));

  p_wake_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PART || st == S_SLUM) && cmd_issue |=> req_wake);

  p_go_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> link_st == 2'b00);

  p_relax_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat_tight) |-> $past(req_slumber && link_ack));

endmodule

// File: tb/tb_sata_lpm_ctrl.sv
module tb_sata_lpm_ctrl;
  localparam int S = 12;
  localparam int D = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_issue = 0, cmd_done = 0, dev_req = 0, link_ack = 0;
  logic [3:0] pend_cnt = 0;
  logic req_partial, req_slumber, req_wake, lat_tight, cmd_go;
  logic [1:0] link_st;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sata_lpm_ctrl #(.CLK_PER_US(1), .SLUMBER_US(S), .DEV_US(D), .PEND_W(4), .HOLD_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_done(cmd_done),
    .pend_cnt(pend_cnt), .dev_req(dev_req), .link_ack(link_ack),
    .req_partial(req_partial), .req_slumber(req_slumber), .req_wake(req_wake),
    .link_st(link_st), .lat_tight(lat_tight), .cmd_go(cmd_go));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue();
    cmd_issue = 1; step(); cmd_issue = 0;
  endtask

  task automatic ack();
    link_ack = 1; step(); link_ack = 0;
  endtask

  task automatic to_partial();
    cmd_done = 1; step(); cmd_done = 0;
    ack();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 state", {link_st, req_partial, req_slumber, req_wake, lat_tight, cmd_go}, 7'b0000010);
    rst_n = 1;
    step();
    chk("R1 after release", {link_st, lat_tight}, 3'b001);

    issue();
    chk("R11 go", cmd_go, 1);
    step();
    chk("R11 single pulse", cmd_go, 0);

    for (int p = 1; p < 16; p++) begin
      pend_cnt = 4'(p);
      cmd_done = 1; step(); cmd_done = 0;
      chk("R3 busy done", {link_st, req_partial}, 3'b000);
    end

    pend_cnt = 5;
    repeat (3 * S) step();
    chk("R5 no slumber busy", {link_st, req_slumber}, 3'b000);

    pend_cnt = 0;
    cmd_done = 1; step(); cmd_done = 0;
    chk("R2 immediate partial", {link_st, req_partial}, 3'b111);
    repeat (4) step();
    chk("R9 request held", req_partial, 1);
    ack();
    chk("R9 partial reached", {link_st, req_partial, lat_tight}, 4'b0101);

    repeat (6) step();
    cmd_done = 1; step(); cmd_done = 0;
    repeat (S) step();
    chk("R4 count restarted", {link_st, req_slumber}, 3'b010);
    step();
    chk("R4 slumber request", req_slumber, 1);
    chk("R12 tight in transition", lat_tight, 1);
    ack();
    chk("R12 relaxed in slumber", {link_st, lat_tight}, 3'b100);

    dev_req = 1; cmd_done = 1; step(); cmd_done = 0; step(); dev_req = 0;
    chk("R10 slumber ignores others", link_st, 2'b10);
    issue();
    chk("R10 wake from slumber", {req_wake, lat_tight}, 2'b11);
    ack();
    chk("R10 active after ack", {link_st, cmd_go}, 3'b000);
    step();
    chk("R10 held released", cmd_go, 1);
    step();
    chk("R10 release done", cmd_go, 0);

    for (int n = 1; n <= 4; n++) begin
      to_partial();
      chk("R9 partial for sweep", link_st, 2'b01);
      for (int k = 0; k < n; k++) begin
        issue();
        chk("R10 wake pending", {req_wake, cmd_go}, 2'b10);
      end
      ack();
      chk("R10 no go on ack edge", {link_st, cmd_go}, 3'b000);
      for (int k = 0; k < n; k++) begin
        step();
        chk("R10 release pulse", cmd_go, 1);
      end
      step();
      chk("R10 release count", cmd_go, 0);
    end

    pend_cnt = 2; dev_req = 1; step(); dev_req = 0;
    chk("R6 device within command", req_partial, 1);
    ack();
    repeat (2 * S) step();
    chk("R5 busy partial stays", link_st, 2'b01);
    issue(); ack(); step(); step();
    chk("R10 back active", link_st, 2'b00);

    pend_cnt = 0;
    issue();
    for (int k = 1; k <= D; k++) begin
      dev_req = 1;
      repeat (k) step();
      chk("R7 early drop ignored", {link_st, req_partial}, 3'b000);
      dev_req = 0; step();
    end
    issue();
    dev_req = 1;
    repeat (D) step();
    chk("R7 not yet granted", req_partial, 0);
    step();
    chk("R7 device grant", req_partial, 1);
    dev_req = 0;
    ack();
    issue(); ack(); step(); step();

    issue();
    repeat (S - D) step();
    dev_req = 1;
    repeat (D) step();
    chk("R8 still active", link_st, 2'b00);
    step();
    chk("R8 host wins", {req_slumber, req_partial}, 2'b10);
    dev_req = 0;
    ack();
    chk("R8 slumber reached", {link_st, lat_tight}, 3'b100);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule